// File: doc/BRIEF.md
# Byte Serial Shifter with Two-Wire Arbitration

The block is a byte-wide synchronous serial shifter seen by software as two 8-bit registers, a data register and a control/status register. In plain mode it acts as a clock-generating master. Writing the data register launches a byte, most significant bit first. The bits sampled from the serial input enter at bit 0 of the same register, so at the end of the byte it holds the received value. Clock polarity, clock phase and one of four clock rates are selectable.

Setting the bus-mode bit makes the same shifter a participant on a shared two-wire bus. At each sampling point it compares the level it drives against the level on the data line. If it releases the line high and reads it low, it has lost arbitration: it raises a flag and holds its data output high until software next writes the data register. It also waits while another master holds the clock line low, and it reports start conditions (data falls while the clock is high) and stop conditions (data rises while the clock is high). The clock and data outputs each have an output enable for the pad, and these follow the enable bit.

Top module: `spi_arb_shifter`

## Requirements
- R1: When the enable bit is 1 and the block is idle, a write to address 0 (the data register) starts a byte transfer. The busy flag (control bit 4) reads 1 from the next cycle and returns to 0 after the 16th clock edge of the byte.
- R2: The transmitted byte leaves most significant bit first. Each sampled input bit is shifted in at bit 0, so after a transfer a read of address 0 returns the received byte.
- R3: Address 1 is the control register. Bit 7 is enable, bit 6 bus mode, bit 5 arbitration flag, bit 4 busy, bit 3 clock polarity, bit 2 clock phase and bits 1:0 the rate. It reads 00h after reset.
- R4: With the enable bit at 0, both output enables are 0 and data writes start nothing. With the enable bit at 1, both output enables are 1.
- R5: The rate field r sets a half clock period of 2<<r system cycles, which is a divide of 4, 8, 16 or 32. A byte takes 16*(2<<r) cycles from the write to the clearing of busy.
- R6: When no transfer is active the clock output rests at the polarity bit. With phase 0, input is sampled on each leading clock edge. With phase 1, input is sampled on each trailing clock edge.
- R7: A control write with bit 6 at 0 re-initialises the shifter. It aborts a running transfer, so busy reads 0 in the next cycle and the clock returns to its idle level, and it ends the forced-high state of the data output.
- R8: In bus mode, polarity and phase act as 0, so sampling happens on the rising clock edge. If the block outputs 1 and samples 0 there, it sets the arbitration flag. Its data output then stays at 1 until the next accepted data write, while the byte still completes and keeps receiving.
- R9: Software clears the arbitration flag by writing 0 to control bit 5; writing 1 there does not set it. If a loss and a clearing write fall in the same cycle, the flag ends up set.
- R10: In bus mode, while the block's own clock is high but the clock input reads low, the bit timing is frozen, and it resumes when the clock input goes high.
- R11: In bus mode, a falling data input while the clock input is high produces a one-cycle start pulse. A rising data input while the clock input is high produces a one-cycle stop pulse and clears the arbitration flag.
- R12: A data write while busy is ignored. The transmitted byte, the received byte and the transfer length are unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 1 | Write address: 0 data, 1 control |
| wr_data | input | 8 | Write value |
| rd_addr | input | 1 | Read address: 0 data, 1 control |
| rd_data | output | 8 | Read value of the addressed register |
| sck_o | output | 1 | Serial clock output |
| sck_oe | output | 1 | Output enable for the clock pad |
| sck_i | input | 1 | Level sensed on the clock line |
| sdo_o | output | 1 | Serial data output |
| sdo_oe | output | 1 | Output enable for the data pad |
| sdi_i | input | 1 | Level sensed on the data line |
| start_o | output | 1 | One-cycle start condition pulse |
| stop_o | output | 1 | One-cycle stop condition pulse |

## Verification
Two functions can meet in one cycle: the hardware setting of the arbitration flag and a software write that clears it. The bench provokes this in bus mode. Another master holds the data line low, the block sends a byte whose first bit is 1, and a control write with bit 5 at 0 is placed in exactly the cycle of the first rising-edge sample, two cycles after the data write at the fastest rate. The flag must read 1 afterwards. Separate scenarios confirm that the same clearing write works when no loss competes with it, and that a stop condition also clears the flag.

// File: rtl/spi_arb_pkg.sv
package spi_arb_pkg;

  localparam int unsigned RATE_W   = 2;
  localparam int unsigned MIN_HALF = 2;
  localparam int unsigned MAX_HALF = MIN_HALF << ((1 << RATE_W) - 1);
  localparam int unsigned TIMER_W  = $clog2(MAX_HALF);

  // control/status register, bit 7 first
  typedef struct packed {
    logic              en;
    logic              bms;
    logic              arb;
    logic              busy;
    logic              cpol;
    logic              cpha;
    logic [RATE_W-1:0] rate;
  } ctrl_t;

  localparam int unsigned CTRL_W = $bits(ctrl_t);

  // last timer count of one half clock period for a rate code
  function automatic logic [TIMER_W-1:0] half_last(input logic [RATE_W-1:0] rate);
    half_last = TIMER_W'((MIN_HALF << rate) - 1);
  endfunction

  // clock edge index parity that samples input for a phase setting
  function automatic logic is_capture(input logic edge_lsb, input logic cpha);
    is_capture = (edge_lsb == cpha);
  endfunction

endpackage

// File: rtl/spi_arb_clkgen.sv
module spi_arb_clkgen
  import spi_arb_pkg::*;
#(
  parameter int unsigned DW = 8,
  localparam int unsigned EW = $clog2(2 * DW)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic              run,
  input  logic              stall,
  input  logic              idle_lvl,
  input  logic [RATE_W-1:0] rate,
  output logic              tick,
  output logic              last,
  output logic              sck,
  output logic [EW-1:0]     edge_idx
);

  logic [TIMER_W-1:0] timer_q;
  logic               at_end;

  assign at_end = (timer_q == half_last(rate));
  assign tick   = run & ~stall & at_end;
  assign last   = tick & (edge_idx == EW'(2 * DW - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      timer_q  <= '0;
      edge_idx <= '0;
      sck      <= 1'b0;
    end else if (load) begin
      timer_q  <= '0;
      edge_idx <= '0;
      sck      <= idle_lvl;
    end else if (tick) begin
      timer_q  <= '0;
      edge_idx <= edge_idx + 1'b1;
      sck      <= ~sck;
    end else if (run && !stall) begin
      timer_q  <= timer_q + 1'b1;
    end else if (!run) begin
      sck      <= idle_lvl;
    end
  end

endmodule

// File: rtl/spi_arb_shift.sv
module spi_arb_shift
  import spi_arb_pkg::*;
#(
  parameter int unsigned DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [DW-1:0] load_data,
  input  logic          tick,
  input  logic          edge_lsb,
  input  logic          cpha,
  input  logic          bus_mode,
  input  logic          sdi,
  input  logic          clear,
  output logic [DW-1:0] data,
  output logic          obit,
  output logic          lost,
  output logic          lost_evt
);

  logic capture;
  logic launch;

  assign capture  = tick & is_capture(edge_lsb, cpha);
  assign launch   = tick & ~capture;
  // released high but the line reads low at a sampling point
  assign lost_evt = capture & bus_mode & ~lost & obit & ~sdi;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      data <= '0;
      obit <= 1'b0;
    end else if (load) begin
      data <= load_data;
      obit <= load_data[DW-1];
    end else begin
      if (capture) data <= {data[DW-2:0], sdi};
      if (launch)  obit <= data[DW-1];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              lost <= 1'b0;
    else if (load || clear)  lost <= 1'b0;
    else if (lost_evt)       lost <= 1'b1;
  end

endmodule

// File: rtl/spi_arb_cond.sv
module spi_arb_cond (
  input  logic clk,
  input  logic rst_n,
  input  logic enable,
  input  logic scl,
  input  logic sda,
  output logic start_evt,
  output logic stop_evt
);

  logic [1:0] scl_h;
  logic [1:0] sda_h;
  logic       clk_high;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_h <= '0;
      sda_h <= '0;
    end else begin
      scl_h <= {scl_h[0], scl};
      sda_h <= {sda_h[0], sda};
    end
  end

  assign clk_high  = scl_h[0] & scl_h[1];
  assign start_evt = enable & clk_high & sda_h[1] & ~sda_h[0];
  assign stop_evt  = enable & clk_high & ~sda_h[1] & sda_h[0];

endmodule

// File: rtl/spi_arb_shifter.sv
module spi_arb_shifter
  import spi_arb_pkg::*;
#(
  parameter int unsigned DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic          wr_addr,
  input  logic [DW-1:0] wr_data,
  input  logic          rd_addr,
  output logic [DW-1:0] rd_data,
  output logic          sck_o,
  output logic          sck_oe,
  input  logic          sck_i,
  output logic          sdo_o,
  output logic          sdo_oe,
  input  logic          sdi_i,
  output logic          start_o,
  output logic          stop_o
);

  localparam int unsigned EW = $clog2(2 * DW);

  ctrl_t         ctrl_q;
  ctrl_t         ctrl_d;
  ctrl_t         wr_c;
  logic          wr_ctl;
  logic          wr_dat;
  logic          start;
  logic          reinit;
  logic          en_q;
  logic          bms_q;
  logic          arb_q;
  logic          busy_q;
  logic          cpol_eff;
  logic          cpha_eff;
  logic          stall;
  logic          tick;
  logic          last;
  logic          sck_int;
  logic [EW-1:0] edge_idx;
  logic [DW-1:0] shreg;
  logic          obit;
  logic          lost;
  logic          lost_evt;
  logic          start_evt;
  logic          stop_evt;

  assign wr_c     = ctrl_t'(wr_data[CTRL_W-1:0]);
  assign wr_ctl   = wr_en & wr_addr;
  assign wr_dat   = wr_en & ~wr_addr;

  assign en_q     = ctrl_q.en;
  assign bms_q    = ctrl_q.bms;
  assign arb_q    = ctrl_q.arb;
  assign busy_q   = ctrl_q.busy;

  assign start    = wr_dat & en_q & ~busy_q;
  assign reinit   = wr_ctl & ~wr_c.bms;
  assign cpol_eff = bms_q ? 1'b0 : ctrl_q.cpol;
  assign cpha_eff = bms_q ? 1'b0 : ctrl_q.cpha;
  assign stall    = bms_q & busy_q & sck_int & ~sck_i;

  always_comb begin
    ctrl_d = ctrl_q;
    if (wr_ctl) ctrl_d = wr_c;
    if (lost_evt)      ctrl_d.arb = 1'b1;
    else if (stop_evt) ctrl_d.arb = 1'b0;
    else if (wr_ctl)   ctrl_d.arb = ctrl_q.arb & wr_c.arb;
    else               ctrl_d.arb = ctrl_q.arb;
    if (reinit)        ctrl_d.busy = 1'b0;
    else if (start)    ctrl_d.busy = 1'b1;
    else if (last)     ctrl_d.busy = 1'b0;
    else               ctrl_d.busy = ctrl_q.busy;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ctrl_q <= '0;
    else        ctrl_q <= ctrl_d;
  end

  spi_arb_clkgen #(.DW(DW)) u_clk (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (start),
    .run      (busy_q),
    .stall    (stall),
    .idle_lvl (cpol_eff),
    .rate     (ctrl_q.rate),
    .tick     (tick),
    .last     (last),
    .sck      (sck_int),
    .edge_idx (edge_idx)
  );

  spi_arb_shift #(.DW(DW)) u_shift (
    .clk       (clk),
    .rst_n     (rst_n),
    .load      (start),
    .load_data (wr_data),
    .tick      (tick),
    .edge_lsb  (edge_idx[0]),
    .cpha      (cpha_eff),
    .bus_mode  (bms_q),
    .sdi       (sdi_i),
    .clear     (reinit),
    .data      (shreg),
    .obit      (obit),
    .lost      (lost),
    .lost_evt  (lost_evt)
  );

  spi_arb_cond u_cond (
    .clk       (clk),
    .rst_n     (rst_n),
    .enable    (bms_q),
    .scl       (sck_i),
    .sda       (sdi_i),
    .start_evt (start_evt),
    .stop_evt  (stop_evt)
  );

  assign sck_oe  = en_q;
  assign sdo_oe  = en_q;
  assign sck_o   = busy_q ? sck_int : cpol_eff;
  assign sdo_o   = lost | obit;
  assign start_o = start_evt;
  assign stop_o  = stop_evt;
  assign rd_data = rd_addr ? DW'(ctrl_q) : shreg;

endmodule

// File: rtl/spi_arb_shifter_chk.sv
module spi_arb_shifter_chk #(
  parameter int unsigned DW = 8,
  localparam int unsigned EW = $clog2(2 * DW)
) (
  input logic          clk,
  input logic          rst_n,
  input logic          wr_en,
  input logic          wr_addr,
  input logic          en_q,
  input logic          busy_q,
  input logic          bms_q,
  input logic          arb_q,
  input logic          lost,
  input logic          lost_evt,
  input logic          stop_evt,
  input logic          stall,
  input logic          tick,
  input logic [EW-1:0] edge_idx,
  input logic          sck_int,
  input logic          reinit,
  input logic          cpol_eff
);

  p_start_busy_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !wr_addr && en_q && !busy_q) |=> busy_q);

  p_disabled_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !wr_addr && !en_q && !busy_q) |=> !busy_q);

  p_idle_level_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(busy_q) && !$past(reinit)) |-> (sck_int == cpol_eff));

  p_reinit_r7: assert property (@(posedge clk) disable iff (!rst_n)
    reinit |=> (!busy_q && !lost));

  p_arb_source_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(arb_q) |-> $past(bms_q && busy_q));

  p_hw_wins_r9: assert property (@(posedge clk) disable iff (!rst_n)
    lost_evt |=> arb_q);

  p_stall_r10: assert property (@(posedge clk) disable iff (!rst_n)
    stall |=> $stable(edge_idx));

  p_stop_clear_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (stop_evt && !lost_evt) |=> !arb_q);

  p_busy_write_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !wr_addr && busy_q && !tick) |=> $stable(edge_idx));

endmodule

bind spi_arb_shifter spi_arb_shifter_chk #(.DW(DW)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .wr_en    (wr_en),
  .wr_addr  (wr_addr),
  .en_q     (en_q),
  .busy_q   (busy_q),
  .bms_q    (bms_q),
  .arb_q    (arb_q),
  .lost     (lost),
  .lost_evt (lost_evt),
  .stop_evt (stop_evt),
  .stall    (stall),
  .tick     (tick),
  .edge_idx (edge_idx),
  .sck_int  (sck_int),
  .reinit   (reinit),
  .cpol_eff (cpol_eff)
);

// File: tb/sim_spi_arb_shifter.sv
module sim_spi_arb_shifter;

  localparam int CLK_PERIOD = 10;

  logic       clk;
  logic       rst_n;
  logic       wr_en;
  logic       wr_addr;
  logic [7:0] wr_data;
  logic       rd_addr;
  logic [7:0] rd_data;
  logic       sck_o, sck_oe, sck_i;
  logic       sdo_o, sdo_oe, sdi_i;
  logic       start_o, stop_o;

  // line models: 0 loopback, 1 bench slave, 2 wired-AND with another master
  logic [1:0] line_mode;
  logic       other, hold_low, ext_en, ext_val;
  logic       slave_sdi;

  int errs = 0;
  int checks = 0;
  int start_cnt = 0;
  int stop_cnt = 0;

  // bench slave
  bit         s_on, s_cpol, s_cpha;
  int         s_idx;
  logic [7:0] s_tx, s_rx;
  logic       sck_prev;

  assign slave_sdi = (s_idx >= 0 && s_idx < 8) ? s_tx[s_idx] : 1'b0;
  assign sdi_i = (line_mode == 2'd0) ? sdo_o :
                 (line_mode == 2'd1) ? slave_sdi : (sdo_o & other);
  assign sck_i = ext_en ? ext_val : (sck_o & ~hold_low);

  spi_arb_shifter u0 (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
    .sck_o(sck_o), .sck_oe(sck_oe), .sck_i(sck_i),
    .sdo_o(sdo_o), .sdo_oe(sdo_oe), .sdi_i(sdi_i),
    .start_o(start_o), .stop_o(stop_o)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD / 2) clk = ~clk;

  always @(posedge clk) begin
    if (start_o) start_cnt <= start_cnt + 1;
    if (stop_o)  stop_cnt  <= stop_cnt + 1;
  end

  always @(negedge clk) begin : slave_blk
    logic lead;
    if (s_on && sck_o != sck_prev) begin
      lead = (sck_o != s_cpol);
      if (lead ^ s_cpha) s_rx = {s_rx[6:0], sdo_o};
      else               s_idx = s_idx - 1;
    end
    sck_prev = sck_o;
  end

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errs++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic a, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic a, output logic [7:0] v);
    rd_addr = a;
    #1;
    v = rd_data;
  endtask

  task automatic wait_idle(output int n);
    logic [7:0] v;
    n = 0;
    rd(1'b1, v);
    while (v[4] && n < 5000) begin
      @(negedge clk);
      n++;
      rd(1'b1, v);
    end
  endtask

  task automatic t_reset();
    logic [7:0] v;
    rd(1'b1, v);
    chk("R3 control reset value", v, 8'h00);
    chk("R4 clock enable off", sck_oe, 0);
    chk("R4 data enable off", sdo_oe, 0);
    wr(1'b0, 8'h55);
    rd(1'b1, v);
    chk("R4 write while disabled starts nothing", v[4], 0);
    wr(1'b1, 8'h80);
    rd(1'b1, v);
    chk("R3 control readback", v, 8'h80);
    chk("R4 clock enable on", sck_oe, 1);
    chk("R4 data enable on", sdo_oe, 1);
  endtask

  task automatic t_mode(input bit cpol, input bit cpha, input logic [7:0] tx, input logic [7:0] sx);
    logic [7:0] v;
    int n;
    wr(1'b1, {4'b1000, cpol, cpha, 2'b00});
    repeat (3) @(negedge clk);
    chk("R6 clock idle level", sck_o, cpol);
    s_cpol = cpol; s_cpha = cpha; s_tx = sx; s_rx = 8'h00;
    s_idx = cpha ? 8 : 7;
    sck_prev = sck_o;
    line_mode = 2'd1;
    s_on = 1'b1;
    wr(1'b0, tx);
    rd(1'b1, v);
    chk("R1 busy after data write", v[4], 1);
    wait_idle(n);
    chk("R5 byte length at rate 0", n, 32);
    rd(1'b0, v);
    chk("R2 R6 received byte", v, sx);
    chk("R2 msb-first transmit seen by slave", s_rx, tx);
    chk("R6 clock back at idle", sck_o, cpol);
    s_on = 1'b0;
  endtask

  task automatic t_rates();
    logic [7:0] v;
    int n;
    line_mode = 2'd0;
    for (int r = 0; r < 4; r++) begin
      wr(1'b1, 8'h80 | 8'(r));
      wr(1'b0, 8'h96 ^ 8'(r));
      wait_idle(n);
      chk("R5 byte length per rate", n, 16 * (2 << r));
      rd(1'b0, v);
      chk("R2 loopback data per rate", v, 8'h96 ^ 8'(r));
    end
  endtask

  task automatic t_busy_write();
    logic [7:0] v;
    int n;
    line_mode = 2'd0;
    wr(1'b1, 8'h81);
    wr(1'b0, 8'hA5);
    repeat (5) @(negedge clk);
    wr(1'b0, 8'h3C);
    wait_idle(n);
    chk("R12 length unchanged by busy write", 7 + n, 64);
    rd(1'b0, v);
    chk("R12 data unchanged by busy write", v, 8'hA5);
  endtask

  task automatic t_reinit();
    logic [7:0] v;
    wr(1'b1, 8'h8B);
    repeat (2) @(negedge clk);
    wr(1'b0, 8'hFF);
    repeat (20) @(negedge clk);
    wr(1'b1, 8'h8B);
    rd(1'b1, v);
    chk("R7 abort clears busy", v[4], 0);
    chk("R7 clock back at idle", sck_o, 1);
  endtask

  task automatic t_arb();
    logic [7:0] v;
    int n;
    line_mode = 2'd2;
    other = 1'b0;
    wr(1'b1, 8'hC0);
    wr(1'b1, 8'hE0);
    rd(1'b1, v);
    chk("R9 writing one does not set flag", v[5], 0);
    // collision: clearing write lands on the first sampling edge
    wr(1'b0, 8'h80);
    wr(1'b1, 8'hC0);
    rd(1'b1, v);
    chk("R9 hardware set wins over clear", v[5], 1);
    chk("R8 data forced high after loss", sdo_o, 1);
    wait_idle(n);
    chk("R8 byte completes after loss", n, 30);
    rd(1'b0, v);
    chk("R8 receive continues after loss", v, 8'h00);
    chk("R8 data still forced high", sdo_o, 1);
    // stop and start conditions
    ext_val = 1'b1; ext_en = 1'b1;
    repeat (3) @(negedge clk);
    begin
      int st0, sc0;
      st0 = stop_cnt; sc0 = start_cnt;
      other = 1'b1;
      repeat (4) @(negedge clk);
      chk("R11 one stop pulse", stop_cnt, st0 + 1);
      rd(1'b1, v);
      chk("R11 stop clears flag", v[5], 0);
      other = 1'b0;
      repeat (4) @(negedge clk);
      chk("R11 one start pulse", start_cnt, sc0 + 1);
    end
    ext_en = 1'b0;
    repeat (3) @(negedge clk);
    chk("R8 forced high until data write", sdo_o, 1);
    // second loss, then software clear with nothing competing
    wr(1'b0, 8'h80);
    wait_idle(n);
    rd(1'b1, v);
    chk("R8 flag set by loss", v[5], 1);
    wr(1'b1, 8'hC0);
    rd(1'b1, v);
    chk("R9 software clear", v[5], 0);
    wr(1'b0, 8'h00);
    chk("R8 data write ends forced high", sdo_o, 0);
    wait_idle(n);
  endtask

  task automatic t_sync();
    logic [7:0] v;
    int n;
    wr(1'b1, 8'hC8);
    repeat (2) @(negedge clk);
    chk("R8 bus mode ignores polarity", sck_o, 0);
    line_mode = 2'd2;
    other = 1'b1;
    hold_low = 1'b1;
    wr(1'b0, 8'h00);
    repeat (40) @(negedge clk);
    rd(1'b1, v);
    chk("R10 busy while clock held low", v[4], 1);
    chk("R10 own clock waiting high", sck_o, 1);
    hold_low = 1'b0;
    wait_idle(n);
    chk("R10 remaining edges after release", n, 30);
    rd(1'b0, v);
    chk("R10 received byte", v, 8'h00);
  endtask

  initial begin
    rst_n = 1'b0; wr_en = 1'b0; wr_addr = 1'b0; wr_data = 8'h00; rd_addr = 1'b1;
    line_mode = 2'd0; other = 1'b1; hold_low = 1'b0; ext_en = 1'b0; ext_val = 1'b0;
    s_on = 1'b0; s_cpol = 1'b0; s_cpha = 1'b0; s_idx = -1; s_tx = 8'h00; s_rx = 8'h00;
    sck_prev = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_mode(1'b0, 1'b0, 8'hC3, 8'h5A);
    t_mode(1'b0, 1'b1, 8'h81, 8'h3E);
    t_mode(1'b1, 1'b0, 8'h17, 8'hE8);
    t_mode(1'b1, 1'b1, 8'hF0, 8'h0D);
    t_rates();
    t_busy_write();
    t_reinit();
    t_arb();
    t_sync();
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 150000);
    errs++;
    checks++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

endmodule